// File: doc/BRIEF.md
# DMA Channel-Start and Interrupt Control

This block is the register and control half of a seven-channel DMA engine. It holds, for every channel, a base-address word, a block-count word and a control word. Next to them sit a global enable word and one shared interrupt control word. A register bus writes and reads all of them. A write to a channel's control word with the start bit set fires a one-cycle start pulse toward that channel's data mover, provided the channel's start-enable bit in the global enable word is set. Moving the data is not part of this block.

Each data mover reports the end of a transfer on a per-channel done line. If that channel's flag enable is set, the done event latches a sticky flag in the interrupt control word. Software clears a flag by writing a one to it. A master flag is formed every cycle from the flags, the global interrupt enable and a bus-error bit. The block issues a single-cycle interrupt request toward the system interrupt controller each time the master flag rises.

Top module: `dma_irq_start_ctrl`

## Requirements
- R1: After reset every register reads 0, and `ch_start`, `irq_pulse` and `rdata` are 0.
- R2: The register window uses 8-bit byte offsets. Channel n (0..6) has its base word at 0x80+0x10*n, its count word at +0x4 and its control word at +0x8. All three are 32-bit read/write words that return the last value written.
- R3: A write to the control word of channel n with data bit 24 set raises `ch_start[n]` for exactly the one cycle after the write edge, but only if bit 4*n+3 of the global enable word is 1 at the time of the write. Any other write leaves `ch_start` at 0.
- R4: In the interrupt control word at 0xF4, a write stores only the bits under mask 0x00FF803F, which are bits 5..0, bit 15 (bus error), bits 22..16 (flag enable of channel n at bit 16+n) and bit 23 (global interrupt enable). Bits 14..6 always read 0.
- R5: A high `ch_done[n]` while flag enable bit 16+n is 1 sets flag bit 24+n at the next edge. A done event on a channel whose enable bit is 0 does not change the flags.
- R6: Writing 1 to a flag bit in 30..24 clears that flag. Flags written as 0 keep their value.
- R7: If a done event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: Bit 31 of the interrupt control word reads as (bit 23 AND any flag in 30..24) OR bit 15, updated in the same cycle as the bits it depends on. Bit 31 cannot be written.
- R9: `irq_pulse` is high for one cycle in the cycle where bit 31 changes from 0 to 1. It stays low while bit 31 remains 1. After bit 31 falls, the next rise produces a new pulse.
- R10: The global enable word at 0xF0 is a 32-bit read/write word.
- R11: Offsets outside the mapped words, including slot +0xC of each channel, read as 0, and writes to them change no register.
- R12: `rdata` is registered. It takes the addressed word one cycle after a read strobe, shows the value from before any write in that same cycle, and holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| ch_done | input | 7 | Per-channel transfer-complete events |
| rdata | output | 32 | Registered read data |
| ch_start | output | 7 | Per-channel one-cycle start pulses |
| irq_pulse | output | 1 | One-cycle interrupt request on a master-flag rise |

## Verification
A wrong flag or a wrong enable bit shows up on `irq_pulse` in the cycle after the done event or the write that should have raised the master flag. It also shows up in the next read of 0xF4, one cycle after the read strobe. A lost or stuck master flag has a visible effect only when a later event should raise it: it then causes either a missing pulse or a spurious one. That is why the stimulus clears every flag and then raises new ones. A corrupted enable or control word is caught on `ch_start` one cycle after the next control-word write, or on readback.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned ADDR_W        = 8;
  localparam int unsigned CH_IDX_W      = 3;
  localparam logic [31:0] ICR_WR_MASK   = 32'h00FF_803F;
  localparam int unsigned ICR_BUSERR    = 15;
  localparam int unsigned ICR_EN_LSB    = 16;
  localparam int unsigned ICR_GIE       = 23;
  localparam int unsigned ICR_FLAG_LSB  = 24;
  localparam int unsigned ICR_MASTER    = 31;
  localparam int unsigned CTRL_GO_BIT   = 24;
  localparam logic [3:0]  CH_PAGE_FIRST = 4'h8;
  localparam logic [5:0]  GEN_WORD      = 6'h3C;  // byte offset 0xF0
  localparam logic [5:0]  ICR_WORD      = 6'h3D;  // byte offset 0xF4

  typedef enum logic [1:0] {
    SLOT_BASE  = 2'd0,
    SLOT_COUNT = 2'd1,
    SLOT_CTRL  = 2'd2,
    SLOT_NONE  = 2'd3
  } chan_slot_e;

  typedef struct packed {
    logic                hit_chan;
    logic [CH_IDX_W-1:0] ch;
    chan_slot_e          slot;
    logic                hit_gen;
    logic                hit_icr;
  } reg_sel_t;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam logic [4:0] PAGE_END = 5'(CH_PAGE_FIRST) + 5'(NUM_CH);

  logic [3:0] page;
  logic       in_chan;

  assign page    = addr[7:4];
  assign in_chan = (page >= CH_PAGE_FIRST) && ({1'b0, page} < PAGE_END);

  always_comb begin
    sel          = '0;
    sel.slot     = chan_slot_e'(addr[3:2]);
    sel.ch       = CH_IDX_W'(page - CH_PAGE_FIRST);
    sel.hit_chan = in_chan && (addr[3:2] != 2'd3);
    sel.hit_gen  = (addr[7:2] == GEN_WORD);
    sel.hit_icr  = (addr[7:2] == ICR_WORD);
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_t          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] gen_q,
  output logic [DATA_W-1:0] rd_word,
  output logic [NUM_CH-1:0] ch_start
);
  logic [DATA_W-1:0] base_q [NUM_CH];
  logic [DATA_W-1:0] cnt_q  [NUM_CH];
  logic [DATA_W-1:0] ctrl_q [NUM_CH];
  logic [NUM_CH-1:0] go_d;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int unsigned EN_BIT = 4 * n + 3;
    logic hit;
    assign hit = wr_en && sel.hit_chan && (sel.ch == CH_IDX_W'(n));
    // start qualifies on the enable word as it stands before this edge
    assign go_d[n] = hit && (sel.slot == SLOT_CTRL) &&
                     wdata[CTRL_GO_BIT] && gen_q[EN_BIT];

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[n] <= '0;
        cnt_q[n]  <= '0;
        ctrl_q[n] <= '0;
      end else if (hit) begin
        case (sel.slot)
          SLOT_BASE:  base_q[n] <= wdata;
          SLOT_COUNT: cnt_q[n]  <= wdata;
          SLOT_CTRL:  ctrl_q[n] <= wdata;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ch_start <= '0;
    else     ch_start <= go_d;
  end

  always_comb begin
    rd_word = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (sel.hit_chan && (sel.ch == CH_IDX_W'(n))) begin
        case (sel.slot)
          SLOT_BASE:  rd_word = base_q[n];
          SLOT_COUNT: rd_word = cnt_q[n];
          SLOT_CTRL:  rd_word = ctrl_q[n];
          default:    rd_word = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              icr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] ch_done,
  output logic [DATA_W-1:0] icr_word,
  output logic [NUM_CH-1:0] flag_q,
  output logic [NUM_CH-1:0] chen_q,
  output logic              master_q,
  output logic              irq_pulse
);
  localparam int unsigned LOW_W = 6;

  logic [LOW_W-1:0]  low_q, low_d;
  logic              buserr_q, buserr_d;
  logic              gie_q, gie_d;
  logic [NUM_CH-1:0] chen_d, flag_d, clr_mask, set_mask;
  logic              master_d;

  always_comb begin
    low_d    = low_q;
    buserr_d = buserr_q;
    gie_d    = gie_q;
    chen_d   = chen_q;
    clr_mask = '0;
    if (icr_wr) begin
      low_d    = wdata[LOW_W-1:0];
      buserr_d = wdata[ICR_BUSERR];
      gie_d    = wdata[ICR_GIE];
      chen_d   = wdata[ICR_EN_LSB +: NUM_CH];
      clr_mask = wdata[ICR_FLAG_LSB +: NUM_CH];
    end
    // a new completion beats a simultaneous clear so no event is lost
    set_mask = ch_done & chen_q;
    flag_d   = (flag_q & ~clr_mask) | set_mask;
    master_d = (gie_d && (|flag_d)) || buserr_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q     <= '0;
      buserr_q  <= 1'b0;
      gie_q     <= 1'b0;
      chen_q    <= '0;
      flag_q    <= '0;
      master_q  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      low_q     <= low_d;
      buserr_q  <= buserr_d;
      gie_q     <= gie_d;
      chen_q    <= chen_d;
      flag_q    <= flag_d;
      master_q  <= master_d;
      irq_pulse <= master_d && !master_q;
    end
  end

  always_comb begin
    icr_word                           = '0;
    icr_word[LOW_W-1:0]                = low_q;
    icr_word[ICR_BUSERR]               = buserr_q;
    icr_word[ICR_EN_LSB +: NUM_CH]     = chen_q;
    icr_word[ICR_GIE]                  = gie_q;
    icr_word[ICR_FLAG_LSB +: NUM_CH]   = flag_q;
    icr_word[ICR_MASTER]               = master_q;
  end
endmodule

// File: rtl/dma_irq_start_ctrl.sv
module dma_irq_start_ctrl
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  input  logic [6:0]        ch_done,
  output logic [31:0]       rdata,
  output logic [6:0]        ch_start,
  output logic              irq_pulse
);
  reg_sel_t          sel;
  logic [DATA_W-1:0] gen_q;
  logic [DATA_W-1:0] chan_rd, icr_word, rd_mux;
  logic [NUM_CH-1:0] flag_q, chen_q;
  logic              master_q;
  logic              icr_wr;

  assign icr_wr = wr_en && sel.hit_icr;

  dma_reg_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  dma_chan_regs #(.NUM_CH(NUM_CH)) u_chan (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .sel      (sel),
    .wdata    (wdata),
    .gen_q    (gen_q),
    .rd_word  (chan_rd),
    .ch_start (ch_start)
  );

  dma_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .icr_wr    (icr_wr),
    .wdata     (wdata),
    .ch_done   (ch_done),
    .icr_word  (icr_word),
    .flag_q    (flag_q),
    .chen_q    (chen_q),
    .master_q  (master_q),
    .irq_pulse (irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)                        gen_q <= '0;
    else if (wr_en && sel.hit_gen)  gen_q <= wdata;
  end

  always_comb begin
    if (sel.hit_chan)     rd_mux = chan_rd;
    else if (sel.hit_gen) rd_mux = gen_q;
    else if (sel.hit_icr) rd_mux = icr_word;
    else                  rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_irq_start_ctrl_chk.sv
module dma_irq_start_ctrl_chk #(
  parameter int unsigned NUM_CH = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              icr_wr,
  input logic [NUM_CH-1:0] ch_done,
  input logic [NUM_CH-1:0] ch_start,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] chen_q,
  input logic              master_q,
  input logic              irq_pulse
);
  p_start_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_start));

  p_start_after_write_r3: assert property (@(posedge clk) disable iff (rst)
    (ch_start != '0) |-> $past(wr_en));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    ((ch_done & chen_q) != '0) |=>
      ((flag_q & $past(ch_done & chen_q)) == $past(ch_done & chen_q)));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !icr_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_master_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(master_q) |-> $past(icr_wr));

  p_irq_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (master_q && !$past(master_q)));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
endmodule

bind dma_irq_start_ctrl dma_irq_start_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .icr_wr    (icr_wr),
  .ch_done   (ch_done),
  .ch_start  (ch_start),
  .flag_q    (flag_q),
  .chen_q    (chen_q),
  .master_q  (master_q),
  .irq_pulse (irq_pulse)
);

// File: tb/dma_irq_start_ctrl_bench.sv
module dma_irq_start_ctrl_bench;
  localparam int NCH = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [6:0]  ch_done = '0;
  logic [31:0] rdata;
  logic [6:0]  ch_start;
  logic        irq_pulse;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R12";

  // behavioural model state
  logic [31:0] m_base [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [31:0] m_ctrl [NCH];
  logic [31:0] m_gen, m_low;
  logic [6:0]  m_flags;
  logic        m_master;
  logic [31:0] exp_rdata;
  logic [6:0]  exp_start;
  logic        exp_irq;

  dma_irq_start_ctrl u_dma_irq_start_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ch_done(ch_done), .rdata(rdata), .ch_start(ch_start),
    .irq_pulse(irq_pulse)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    int pg;
    pg = int'(a[7:4]);
    if (pg >= 8 && pg < 8 + NCH) begin
      case (a[3:2])
        2'd0: return m_base[pg-8];
        2'd1: return m_cnt[pg-8];
        2'd2: return m_ctrl[pg-8];
        default: return 32'h0;
      endcase
    end
    if (a[7:2] == 6'h3C) return m_gen;
    if (a[7:2] == 6'h3D) return m_low | {1'b0, m_flags, 24'h0} | {m_master, 31'h0};
    return 32'h0;
  endfunction

  task automatic model_step();
    int pg;
    logic [6:0] clr, set;
    logic nm;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_base[i] = '0; m_cnt[i] = '0; m_ctrl[i] = '0;
      end
      m_gen = '0; m_low = '0; m_flags = '0; m_master = 1'b0;
      exp_rdata = '0; exp_start = '0; exp_irq = 1'b0;
      return;
    end
    if (rd_en) exp_rdata = m_read(addr);
    exp_start = '0;
    clr = '0;
    set = ch_done & m_low[22:16];
    if (wr_en) begin
      pg = int'(addr[7:4]);
      if (pg >= 8 && pg < 8 + NCH) begin
        case (addr[3:2])
          2'd0: m_base[pg-8] = wdata;
          2'd1: m_cnt[pg-8]  = wdata;
          2'd2: begin
            m_ctrl[pg-8] = wdata;
            if (wdata[24] && m_gen[4*(pg-8)+3]) exp_start[pg-8] = 1'b1;
          end
          default: ;
        endcase
      end else if (addr[7:2] == 6'h3C) begin
        m_gen = wdata;
      end else if (addr[7:2] == 6'h3D) begin
        m_low = wdata & 32'h00FF_803F;
        clr   = wdata[30:24];
      end
    end
    m_flags = (m_flags & ~clr) | set;
    nm = (m_low[23] && (m_flags != 0)) || m_low[15];
    exp_irq = nm && !m_master;
    m_master = nm;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R3 ch_start", 32'(ch_start), 32'(exp_start));
    chk("R9 irq_pulse", 32'(irq_pulse), 32'(exp_irq));
    chk({cur_req, " rdata"}, rdata, exp_rdata);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string req);
    rd_en = 1'b1; addr = a; cur_req = req;
    cyc();
    rd_en = 1'b0;
  endtask

  task automatic done(logic [6:0] m);
    ch_done = m;
    cyc();
    ch_done = '0;
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    // R1: reset state
    chk("R1 ch_start", 32'(ch_start), 32'h0);
    chk("R1 irq_pulse", 32'(irq_pulse), 32'h0);
    for (int i = 0; i < 64; i++) rd(8'(i * 4), "R1");

    // R2: channel words
    wr(8'hB0, 32'hDEAD_BEEF); wr(8'hB4, 32'h0000_1234); wr(8'hB8, 32'h0000_0201);
    wr(8'hE0, 32'h1357_9BDF);
    rd(8'hB0, "R2"); chk("R2 base ch3", rdata, 32'hDEAD_BEEF);
    rd(8'hB4, "R2"); rd(8'hB8, "R2"); rd(8'hE0, "R2");

    // R10: global enable word; ch0 and ch6 start enables
    wr(8'hF0, 32'h0800_0008);
    rd(8'hF0, "R10"); chk("R10 gen", rdata, 32'h0800_0008);

    // R3: start qualification
    wr(8'h88, 32'h0100_0000); chk("R3 ch0 start", 32'(ch_start), 32'h01);
    cyc();                    chk("R3 pulse one cycle", 32'(ch_start), 32'h0);
    wr(8'h98, 32'h0100_0000); chk("R3 ch1 not enabled", 32'(ch_start), 32'h0);
    wr(8'hE8, 32'h0100_0000); chk("R3 ch6 start", 32'(ch_start), 32'h40);
    wr(8'h88, 32'h0000_0001); chk("R3 no go bit", 32'(ch_start), 32'h0);

    // R4/R8: masked write, bus error forces master
    wr(8'hF4, 32'h7FFF_FFFF); chk("R9 buserr irq", 32'(irq_pulse), 32'h1);
    rd(8'hF4, "R4"); chk("R4 masked icr", rdata, 32'h80FF_803F);
    wr(8'hF4, 32'h0000_0000); rd(8'hF4, "R8"); chk("R8 master drops", rdata, 32'h0);

    // R5: enables for all channels except ch2, global enable on
    wr(8'hF4, 32'h00FB_0000);
    done(7'h04);              chk("R5 disabled ch ignored", 32'(irq_pulse), 32'h0);
    rd(8'hF4, "R5");          chk("R5 no flag", rdata, 32'h00FB_0000);
    done(7'h01);              chk("R9 first rise", 32'(irq_pulse), 32'h1);
    done(7'h02);              chk("R9 no pulse while set", 32'(irq_pulse), 32'h0);
    rd(8'hF4, "R5");          chk("R5 flags 24,25", rdata, 32'h83FB_0000);

    // R6: write-one-to-clear
    wr(8'hF4, 32'h01FB_0000); rd(8'hF4, "R6"); chk("R6 clear flag24", rdata, 32'h82FB_0000);
    wr(8'hF4, 32'h02FB_0000); rd(8'hF4, "R6"); chk("R6 all clear", rdata, 32'h00FB_0000);
    done(7'h10);              chk("R9 new rise", 32'(irq_pulse), 32'h1);

    // R7: set and clear same cycle
    ch_done = 7'h10; wr(8'hF4, 32'h10FB_0000); ch_done = '0;
    rd(8'hF4, "R7");          chk("R7 set wins", rdata, 32'h90FB_0000);

    // R11: unmapped offsets
    wr(8'h8C, 32'hFFFF_FFFF); wr(8'hF8, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h8C, "R11"); chk("R11 hole", rdata, 32'h0);
    rd(8'hF8, "R11"); rd(8'h40, "R11");
    rd(8'hF0, "R11"); chk("R11 gen untouched", rdata, 32'h0800_0008);

    // R12: read in write cycle returns old value, then holds
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'hC0; wdata = 32'hAAAA_5555; cur_req = "R12";
    cyc(); rd_en = 1'b0; wr_en = 1'b0;
    chk("R12 old value", rdata, 32'h0);
    cyc(); cyc();

    // mixed traffic against the model
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      ch_done = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h0;
      if (op < 3) begin
        wr_en = 1'b1; wdata = $urandom;
        case ($urandom_range(0, 3))
          0: addr = 8'hF4;
          1: addr = 8'hF0;
          2: addr = {4'($urandom_range(8, 14)), 2'd2, 2'd0};
          default: addr = 8'($urandom);
        endcase
        if (addr == 8'hF4 && $urandom_range(0, 1) == 1) wdata[15] = 1'b0;
        cur_req = "R2";
      end else if (op < 6) begin
        rd_en = 1'b1;
        addr = ($urandom_range(0, 1) == 1) ? 8'hF4 : 8'($urandom);
        cur_req = "R12";
      end
      cyc();
      wr_en = 1'b0; rd_en = 1'b0; ch_done = '0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule